// File: doc/BRIEF.md
# Sub-Thread Checkpoint Controller

This controller sits beside a set of speculative thread contexts and cuts each running thread into a short chain of sub-threads. Every sub-thread marks a point the thread can return to, so a dependence violation costs only the work done since that point and not the whole thread. A new sub-thread begins each time the thread has retired a fixed number of instructions. Every thread has a fixed number of sub-thread slots. When the last slot is in use, the thread stays in that slot until it commits.

Thread slots are ranked by index: a lower thread id is an older thread. Each time a thread opens a sub-thread, the controller records a snapshot of the current sub-thread id of every thread into a per-thread start table. A violation names a thread and one of its sub-threads. That thread is rewound to the named sub-thread. Every active younger thread is rewound in the same cycle to the sub-thread it was running when the violated older sub-thread began. The register checkpoints and the speculative cache state are kept elsewhere. This block only issues the checkpoint pulses and the rewind requests that drive them.

Every command input is taken in the cycle it is presented. None of the inputs carries a payload stream, so the block has no valid/ready handshake and applies no back-pressure. Outputs are registered.

Top module: `sub_thread_ckpt_ctrl`

## Requirements
- R1: After reset every thread is inactive, every `cur_sub` field reads 0, and no `ckpt_pulse` or `rewind_valid` bit is set.
- R2: A start command for thread t makes t active. Its `cur_sub` reads 0 and its instruction count restarts. The start also records, as entry 0 of t's start table, the `cur_sub` of every thread at that moment.
- R3: Suppose an active thread retires instructions while it is not in its last sub-thread. The cycle after its INTERVAL-th retire in the current sub-thread, `ckpt_pulse[t]` is high for exactly one cycle, and `cur_sub[t]` has increased by one in that same cycle. The new slot's start-table entry holds the `cur_sub` value of every thread from just before the increment.
- R4: Once `cur_sub[t]` equals NSUB-1, further retires cause no checkpoint and `cur_sub[t]` stays put until a rewind, start or commit.
- R5: A retire strobe on an inactive thread has no effect on that thread's outputs.
- R6: An accepted violation on thread v with sub-thread s produces a one-cycle `rewind_valid[v]` with `rewind_sub[v]` = s. In that same cycle `cur_sub[v]` = s, and the instruction count restarts, so the next checkpoint needs INTERVAL fresh retires.
- R7: A violation is accepted only if thread v is active and s is no greater than `cur_sub[v]`. Any other violation produces no rewind on any thread.
- R8: On an accepted violation of (v, s), every active thread y > v also pulses `rewind_valid[y]`. Its target is the largest local index k with k <= `cur_sub[y]`, where either k = 0 or entry k of y's table recorded a sub-thread of v below s.
- R9: An accepted violation on thread v never rewinds a thread with an index lower than v, and leaves that thread's `cur_sub` unchanged.
- R10: A commit for thread t makes t inactive and sets `cur_sub[t]` to 0 on the next cycle. It also clears t's start table. A later violation naming t is then ignored.
- R11: For one thread in one cycle the order of precedence is commit, then start, then rewind, then checkpoint. A retire arriving in a rewind, start or commit cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | NT | One retired-instruction strobe per thread |
| start_valid | input | 1 | Thread start command |
| start_tid | input | TW | Thread started by the command |
| commit_valid | input | 1 | Thread commit command |
| commit_tid | input | TW | Thread committed by the command |
| viol_valid | input | 1 | Dependence violation event |
| viol_tid | input | TW | Thread that was violated |
| viol_sub | input | SW | Sub-thread of that thread that was violated |
| cur_sub | output | NT*SW | Current sub-thread id of each thread, field t at bits [t*SW +: SW] |
| ckpt_pulse | output | NT | One-cycle pulse when a thread opens a new sub-thread |
| rewind_valid | output | NT | One-cycle rewind request per thread |
| rewind_sub | output | NT*SW | Rewind target per thread; meaningful only while its `rewind_valid` bit is high |

## Verification
Directed sequences first cover the interval boundary and the saturation in the last slot. They then interleave the checkpoints of two threads so that the start tables hold distinct snapshots. The primary and secondary rewind targets can then come out different, and a wrong comparison in the table lookup moves a target by one slot. Invalid violations cover an inactive thread and a sub-thread id ahead of the thread's current one; these separate the acceptance test from the rewind path. Same-cycle collisions of commit, start, violation and retire expose any mistake in precedence. A long seeded random run mixes all the events and is compared every cycle against a reference model in the bench. That run exposes state interactions the directed cases do not reach.

// File: rtl/stc_pkg.sv
package stc_pkg;
  // Per-thread action chosen by the top level each cycle, highest precedence first.
  typedef enum logic [1:0] {
    ACT_COMMIT = 2'd0,
    ACT_START  = 2'd1,
    ACT_REWIND = 2'd2,
    ACT_RUN    = 2'd3
  } thr_act_e;
endpackage

// File: rtl/stc_thread_seq.sv
// Per-thread sequencer: instruction interval counter, current sub-thread id,
// and the registered checkpoint and rewind pulses.
module stc_thread_seq #(
  parameter int NSUB     = 4,
  parameter int INTERVAL = 16,
  localparam int SW      = $clog2(NSUB),
  localparam int CW      = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stc_pkg::thr_act_e act_i,
  input  logic             retire_i,
  input  logic [SW-1:0]    tgt_i,
  output logic             active_o,
  output logic [SW-1:0]    cur_o,
  output logic             ckpt_due_o,
  output logic             ckpt_o,
  output logic             rewind_o,
  output logic [SW-1:0]    rewind_sub_o
);
  localparam logic [SW-1:0] LAST_SUB = SW'(NSUB - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          may_count;

  assign may_count  = (act_i == stc_pkg::ACT_RUN) && active_o && retire_i && (cur_o != LAST_SUB);
  assign ckpt_due_o = may_count && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o     <= 1'b0;
      cur_o        <= '0;
      cnt_q        <= '0;
      ckpt_o       <= 1'b0;
      rewind_o     <= 1'b0;
      rewind_sub_o <= '0;
    end else begin
      ckpt_o   <= 1'b0;
      rewind_o <= 1'b0;
      unique case (act_i)
        stc_pkg::ACT_COMMIT: begin
          active_o <= 1'b0;
          cur_o    <= '0;
          cnt_q    <= '0;
        end
        stc_pkg::ACT_START: begin
          active_o <= 1'b1;
          cur_o    <= '0;
          cnt_q    <= '0;
        end
        stc_pkg::ACT_REWIND: begin
          cur_o        <= tgt_i;
          cnt_q        <= '0;
          rewind_o     <= 1'b1;
          rewind_sub_o <= tgt_i;
        end
        default: begin
          if (ckpt_due_o) begin
            cnt_q  <= '0;
            cur_o  <= cur_o + SW'(1);
            ckpt_o <= 1'b1;
          end else if (may_count) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/stc_start_table.sv
// Start table: for each thread and each of its sub-thread slots, the sub-thread
// id every thread was in when that slot began. Also computes the secondary
// rewind target of every thread for the violation presented this cycle.
module stc_start_table #(
  parameter int NT   = 4,
  parameter int NSUB = 4,
  localparam int SW  = $clog2(NSUB),
  localparam int TW  = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] start_wr_i,
  input  logic [NT-1:0] ckpt_wr_i,
  input  logic [NT-1:0] clear_i,
  input  logic [SW-1:0] cur_i [NT],
  input  logic [TW-1:0] viol_tid_i,
  input  logic [SW-1:0] viol_sub_i,
  output logic [SW-1:0] sec_tgt_o [NT]
);
  logic [SW-1:0] tbl_q [NT][NSUB][NT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++)
        for (int k = 0; k < NSUB; k++)
          for (int j = 0; j < NT; j++)
            tbl_q[t][k][j] <= '0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (clear_i[t]) begin
          for (int k = 0; k < NSUB; k++)
            for (int j = 0; j < NT; j++)
              tbl_q[t][k][j] <= '0;
        end else if (start_wr_i[t]) begin
          for (int j = 0; j < NT; j++)
            tbl_q[t][0][j] <= cur_i[j];
        end else if (ckpt_wr_i[t]) begin
          for (int j = 0; j < NT; j++)
            tbl_q[t][cur_i[t] + SW'(1)][j] <= cur_i[j];
        end
      end
    end
  end

  // Latest local slot that was already running when the violated older
  // sub-thread began: slot 0, or a slot whose recorded older id is below it.
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      sec_tgt_o[t] = '0;
      for (int k = 1; k < NSUB; k++) begin
        if ((SW'(k) <= cur_i[t]) && (tbl_q[t][k][viol_tid_i] < viol_sub_i))
          sec_tgt_o[t] = SW'(k);
      end
    end
  end
endmodule

// File: rtl/sub_thread_ckpt_ctrl.sv
module sub_thread_ckpt_ctrl #(
  parameter int NT       = 4,
  parameter int NSUB     = 4,
  parameter int INTERVAL = 16,
  localparam int TW      = $clog2(NT),
  localparam int SW      = $clog2(NSUB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NT-1:0]   retire,
  input  logic            start_valid,
  input  logic [TW-1:0]   start_tid,
  input  logic            commit_valid,
  input  logic [TW-1:0]   commit_tid,
  input  logic            viol_valid,
  input  logic [TW-1:0]   viol_tid,
  input  logic [SW-1:0]   viol_sub,
  output logic [NT*SW-1:0] cur_sub,
  output logic [NT-1:0]   ckpt_pulse,
  output logic [NT-1:0]   rewind_valid,
  output logic [NT*SW-1:0] rewind_sub
);
  stc_pkg::thr_act_e thr_act [NT];
  logic [SW-1:0] cur      [NT];
  logic [SW-1:0] tgt      [NT];
  logic [SW-1:0] sec_tgt  [NT];
  logic [SW-1:0] rw_sub   [NT];
  logic [NT-1:0] active;
  logic [NT-1:0] ckpt_due;
  logic [NT-1:0] start_wr;
  logic [NT-1:0] clear;
  logic          viol_ok;

  assign viol_ok = viol_valid && active[viol_tid] && (viol_sub <= cur[viol_tid]);

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      start_wr[t] = 1'b0;
      clear[t]    = 1'b0;
      if (commit_valid && (commit_tid == TW'(t))) begin
        thr_act[t] = stc_pkg::ACT_COMMIT;
        clear[t]   = 1'b1;
      end else if (start_valid && (start_tid == TW'(t))) begin
        thr_act[t]  = stc_pkg::ACT_START;
        start_wr[t] = 1'b1;
      end else if (viol_ok && active[t] && (TW'(t) >= viol_tid)) begin
        thr_act[t] = stc_pkg::ACT_REWIND;
      end else begin
        thr_act[t] = stc_pkg::ACT_RUN;
      end
      tgt[t] = (TW'(t) == viol_tid) ? viol_sub : sec_tgt[t];
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_thr
    stc_thread_seq #(
      .NSUB     (NSUB),
      .INTERVAL (INTERVAL)
    ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_i        (thr_act[g]),
      .retire_i     (retire[g]),
      .tgt_i        (tgt[g]),
      .active_o     (active[g]),
      .cur_o        (cur[g]),
      .ckpt_due_o   (ckpt_due[g]),
      .ckpt_o       (ckpt_pulse[g]),
      .rewind_o     (rewind_valid[g]),
      .rewind_sub_o (rw_sub[g])
    );
    assign cur_sub[g*SW +: SW]    = cur[g];
    assign rewind_sub[g*SW +: SW] = rw_sub[g];
  end

  stc_start_table #(
    .NT   (NT),
    .NSUB (NSUB)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr_i (start_wr),
    .ckpt_wr_i  (ckpt_due),
    .clear_i    (clear),
    .cur_i      (cur),
    .viol_tid_i (viol_tid),
    .viol_sub_i (viol_sub),
    .sec_tgt_o  (sec_tgt)
  );
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int NT   = 4,
  parameter int NSUB = 4,
  localparam int TW  = $clog2(NT),
  localparam int SW  = $clog2(NSUB)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_valid,
  input logic [TW-1:0]   start_tid,
  input logic            commit_valid,
  input logic [TW-1:0]   commit_tid,
  input logic [NT*SW-1:0] cur_sub,
  input logic [NT-1:0]   ckpt_pulse,
  input logic [NT-1:0]   rewind_valid,
  input logic [NT*SW-1:0] rewind_sub
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R3: a checkpoint pulse comes with a one-step advance of the sub-thread id
    assert_ckpt_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_pulse[t] |-> (cur_sub[t*SW +: SW] == $past(cur_sub[t*SW +: SW]) + SW'(1)));

    // R4: no checkpoint out of the last slot
    assert_no_ckpt_past_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_pulse[t] |-> ($past(cur_sub[t*SW +: SW]) != SW'(NSUB - 1)));

    // R6: the id takes the rewind target in the pulse cycle
    assert_rewind_sets_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rewind_valid[t] |-> (cur_sub[t*SW +: SW] == rewind_sub[t*SW +: SW]));

    // R8: a rewind never moves a thread forward
    assert_rewind_backward_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rewind_valid[t] |-> (rewind_sub[t*SW +: SW] <= $past(cur_sub[t*SW +: SW])));

    // R10: commit returns the id to zero
    assert_commit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && (commit_tid == TW'(t))) |=> (cur_sub[t*SW +: SW] == '0));

    // R11: checkpoint and rewind never coincide on one thread
    assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ckpt_pulse[t] && rewind_valid[t]));

    // R2: the id only moves through a pulse or a start/commit command
    assert_id_moves_by_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_sub[t*SW +: SW]) |->
        (ckpt_pulse[t] || rewind_valid[t] ||
         $past(start_valid && (start_tid == TW'(t))) ||
         $past(commit_valid && (commit_tid == TW'(t)))));
  end
endmodule

bind sub_thread_ckpt_ctrl stc_checker #(
  .NT   (NT),
  .NSUB (NSUB)
) u_stc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_valid  (start_valid),
  .start_tid    (start_tid),
  .commit_valid (commit_valid),
  .commit_tid   (commit_tid),
  .cur_sub      (cur_sub),
  .ckpt_pulse   (ckpt_pulse),
  .rewind_valid (rewind_valid),
  .rewind_sub   (rewind_sub)
);

// File: tb/tb_sub_thread_ckpt_ctrl.sv
`timescale 1ns/1ps
module tb_sub_thread_ckpt_ctrl;
  localparam int NT   = 4;
  localparam int NSUB = 4;
  localparam int IV   = 4;
  localparam int TW   = $clog2(NT);
  localparam int SW   = $clog2(NSUB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] retire = '0;
  logic start_valid = 1'b0, commit_valid = 1'b0, viol_valid = 1'b0;
  logic [TW-1:0] start_tid = '0, commit_tid = '0, viol_tid = '0;
  logic [SW-1:0] viol_sub = '0;
  logic [NT*SW-1:0] cur_sub, rewind_sub;
  logic [NT-1:0] ckpt_pulse, rewind_valid;

  sub_thread_ckpt_ctrl #(.NT(NT), .NSUB(NSUB), .INTERVAL(IV)) dut (
    .clk(clk), .rst_n(rst_n), .retire(retire),
    .start_valid(start_valid), .start_tid(start_tid),
    .commit_valid(commit_valid), .commit_tid(commit_tid),
    .viol_valid(viol_valid), .viol_tid(viol_tid), .viol_sub(viol_sub),
    .cur_sub(cur_sub), .ckpt_pulse(ckpt_pulse),
    .rewind_valid(rewind_valid), .rewind_sub(rewind_sub));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int m_act [NT], m_cur [NT], m_cnt [NT];
  int m_tbl [NT][NSUB][NT];
  int e_ck [NT], e_rw [NT], e_rs [NT];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sub_of(int t);
    return int'(cur_sub[t*SW +: SW]);
  endfunction

  function automatic int sec_tgt(int y, int vt, int vs);
    int tg = 0;
    for (int k = 1; k < NSUB; k++)
      if (k <= m_cur[y] && m_tbl[y][k][vt] < vs) tg = k;
    return tg;
  endfunction

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      m_act[t] = 0; m_cur[t] = 0; m_cnt[t] = 0;
      e_ck[t] = 0; e_rw[t] = 0; e_rs[t] = 0;
      for (int k = 0; k < NSUB; k++)
        for (int j = 0; j < NT; j++) m_tbl[t][k][j] = 0;
    end
  endtask

  task automatic model(input logic [NT-1:0] r, input bit sv, input int st,
                       input bit cv, input int ct, input bit vv, input int vt, input int vs);
    bit acc;
    int kind [NT];  // 0 commit 1 start 2 rewind 3 run
    acc = vv && m_act[vt] == 1 && vs <= m_cur[vt];
    for (int t = 0; t < NT; t++) begin
      e_ck[t] = 0; e_rw[t] = 0;
      if (cv && ct == t) kind[t] = 0;
      else if (sv && st == t) kind[t] = 1;
      else if (acc && m_act[t] == 1 && t >= vt) kind[t] = 2;
      else kind[t] = 3;
      if (kind[t] == 2) begin
        e_rw[t] = 1;
        e_rs[t] = (t == vt) ? vs : sec_tgt(t, vt, vs);
      end else if (kind[t] == 3 && m_act[t] == 1 && r[t] && m_cur[t] < NSUB-1 && m_cnt[t] == IV-1)
        e_ck[t] = 1;
    end
    for (int t = 0; t < NT; t++) begin
      if (kind[t] == 0) begin
        for (int k = 0; k < NSUB; k++)
          for (int j = 0; j < NT; j++) m_tbl[t][k][j] = 0;
      end else if (kind[t] == 1) begin
        for (int j = 0; j < NT; j++) m_tbl[t][0][j] = m_cur[j];
      end else if (e_ck[t] == 1) begin
        for (int j = 0; j < NT; j++) m_tbl[t][m_cur[t]+1][j] = m_cur[j];
      end
    end
    for (int t = 0; t < NT; t++) begin
      case (kind[t])
        0: begin m_act[t] = 0; m_cur[t] = 0; m_cnt[t] = 0; end
        1: begin m_act[t] = 1; m_cur[t] = 0; m_cnt[t] = 0; end
        2: begin m_cur[t] = e_rs[t]; m_cnt[t] = 0; end
        default: begin
          if (e_ck[t] == 1) begin m_cur[t]++; m_cnt[t] = 0; end
          else if (m_act[t] == 1 && r[t] && m_cur[t] < NSUB-1) m_cnt[t]++;
        end
      endcase
    end
  endtask

  task automatic compare(string req);
    for (int t = 0; t < NT; t++) begin
      check(req, $sformatf("cur_sub[%0d]", t), sub_of(t), m_cur[t]);
      check(req, $sformatf("ckpt_pulse[%0d]", t), int'(ckpt_pulse[t]), e_ck[t]);
      check(req, $sformatf("rewind_valid[%0d]", t), int'(rewind_valid[t]), e_rw[t]);
      if (e_rw[t] == 1)
        check(req, $sformatf("rewind_sub[%0d]", t), int'(rewind_sub[t*SW +: SW]), e_rs[t]);
    end
  endtask

  // Called at a falling edge: drive, update model, sample at the next falling edge.
  task automatic step(string req, input logic [NT-1:0] r,
                      input bit sv = 0, input int st = 0, input bit cv = 0, input int ct = 0,
                      input bit vv = 0, input int vt = 0, input int vs = 0);
    retire = r;
    start_valid = sv;  start_tid = TW'(st);
    commit_valid = cv; commit_tid = TW'(ct);
    viol_valid = vv;   viol_tid = TW'(vt); viol_sub = SW'(vs);
    model(r, sv, st, cv, ct, vv, vt, vs);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic run(string req, input logic [NT-1:0] r, input int n);
    for (int i = 0; i < n; i++) step(req, r);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R5: retires on an inactive thread do nothing
    run("R5", 4'b0100, 2*IV);
    check("R5", "cur_sub[2]", sub_of(2), 0);

    // R2: start threads 0 and 1
    step("R2", '0, 1, 0);
    step("R2", '0, 1, 1);

    // Interleave checkpoints so the tables differ
    run("R3", 4'b0010, IV);      // t1 -> 1, recorded t0=0
    run("R3", 4'b0001, IV);      // t0 -> 1
    run("R3", 4'b0010, IV);      // t1 -> 2, recorded t0=1
    check("R3", "cur_sub[1]", sub_of(1), 2);
    run("R3", 4'b0001, IV);      // t0 -> 2
    check("R3", "cur_sub[0]", sub_of(0), 2);

    // R7: violation on inactive thread, then one ahead of the current id
    step("R7", '0, 0, 0, 0, 0, 1, 3, 0);
    check("R7", "rewind_valid", int'(rewind_valid), 0);
    step("R7", '0, 0, 0, 0, 0, 1, 0, 3);
    check("R7", "rewind_valid", int'(rewind_valid), 0);

    // R6, R8: violate t0 sub 1; t1 must land on its slot 1
    step("R8", '0, 0, 0, 0, 0, 1, 0, 1);
    check("R6", "rewind_sub[0]", int'(rewind_sub[0 +: SW]), 1);
    check("R8", "rewind_sub[1]", int'(rewind_sub[SW +: SW]), 1);
    check("R6", "cur_sub[0]", sub_of(0), 1);

    // R6: interval restarts after rewind
    run("R6", 4'b0001, IV-1);
    check("R6", "cur_sub[0]", sub_of(0), 1);
    step("R6", 4'b0001);
    check("R6", "ckpt_pulse[0]", int'(ckpt_pulse[0]), 1);

    // R9: violating t1 leaves older t0 alone
    step("R9", '0, 0, 0, 0, 0, 1, 1, 0);
    check("R9", "rewind_valid[0]", int'(rewind_valid[0]), 0);
    check("R9", "cur_sub[0]", sub_of(0), 2);

    // R4: drive t0 to the last slot and beyond
    run("R4", 4'b0001, 4*IV);
    check("R4", "cur_sub[0]", sub_of(0), NSUB-1);
    step("R4", 4'b0001);
    check("R4", "ckpt_pulse[0]", int'(ckpt_pulse[0]), 0);

    // R11: commit t1 with a violation on t0 in one cycle; start vs retire
    step("R11", 4'b0011, 0, 0, 1, 1, 1, 0, 0);
    check("R11", "rewind_valid[1]", int'(rewind_valid[1]), 0);
    check("R11", "rewind_valid[0]", int'(rewind_valid[0]), 1);
    step("R11", 4'b0010, 1, 1);
    run("R11", 4'b0010, IV-1);
    check("R11", "cur_sub[1]", sub_of(1), 0);
    step("R11", 4'b0010);
    check("R11", "ckpt_pulse[1]", int'(ckpt_pulse[1]), 1);

    // R10: commit t0 then violate it
    step("R10", '0, 0, 0, 1, 0);
    check("R10", "cur_sub[0]", sub_of(0), 0);
    step("R10", '0, 0, 0, 0, 0, 1, 0, 0);
    check("R10", "rewind_valid", int'(rewind_valid), 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [NT-1:0] r;
      bit sv, cv, vv;
      int st, ct, vt, vs;
      for (int t = 0; t < NT; t++) r[t] = ($urandom % 4) != 0;
      sv = ($urandom % 16) == 0; st = $urandom % NT;
      cv = ($urandom % 32) == 0; ct = $urandom % NT;
      vv = ($urandom % 8) == 0;  vt = $urandom % NT; vs = $urandom % NSUB;
      step("random(R2,R3,R6,R8)", r, sv, st, cv, ct, vv, vt, vs);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule